// File: doc/BRIEF.md
# Critical-Bit Completion Pipeline

This block is a cycle-level model of a latchless domino pipeline that mixes two data encodings. Every stage carries one dual-rail critical bit and a word of single-rail data. The critical bit comes from a synchronizing AND gate, which stays at spacer until all of its inputs are valid. This makes it the last signal in the stage to settle, so a single NOR on its two rails is enough to report stage completion, however wide the word is. Each stage's done signal acts as the precharge/evaluate control of the stage before it. The single-rail bits have no completion signal of their own. They are captured on the same event that captures the critical bit.

Single-rail bits that feed a dual-rail gate pass through a converter. The converter always outputs a valid code: logic 0 while its producer is in precharge, and the bit value while its producer is evaluating. Stages come in two kinds. A direct stage ANDs the incoming critical bit with one converted data bit. A latch-linked stage ANDs two converted data bits and uses the incoming critical bit only as an enable. The last stage feeds two consumers. A C-element joins their ready signals before they become the last stage's control.

A source hands over one token at a time: a critical value plus a data word, followed by a spacer, paced by the first stage's done output. Consumers take tokens from the last stage and return to ready once it has precharged.

Top module: `cpc_pipeline`

## Requirements
- R1: During reset, every stage holds spacer. All done outputs read 1, both output rails read 0 and the output data reads 0.
- R2: Critical rail coding: (1,0) is logic 1, (0,1) is logic 0 and (0,0) is spacer. No stage ever drives (1,1).
- R3: A stage leaves spacer only in the cycle after its incoming critical bit was valid. For a latch-linked stage, that bit is the enable.
- R4: A stage evaluates only while its control is high. The control of stage s is the done of stage s+1, and the control of the last stage is the C-element output. When it evaluates, the stage captures its incoming data rotated left by one bit.
- R5: When a stage's control is low, the next cycle leaves its critical bit at spacer and its data at zero.
- R6: Once a stage is valid, its critical bit and data hold steady while its control stays high, whatever its inputs do.
- R7: In a direct stage (mask bit 0), the critical value is incoming critical AND incoming data bit 0. In a latch-linked stage (mask bit 1), it is incoming data bit 0 AND bit 1. The default mask is 4'b1010, so stages 1 and 3 are latch-linked.
- R8: A converter outputs (0,1) while its producer precharges and (bit, not bit) while its producer evaluates. It is never spacer. A stage only captures while its converters are armed.
- R9: done[s] is the NOR of stage s's two critical rails. done[0] is the acknowledge to the source.
- R10: The last stage's control goes to evaluate when both consumers are ready and to precharge when neither is. When the two disagree, the control keeps its previous value, so a valid output stays valid.
- R11: Source data presented while the source critical bit is spacer is ignored.
- R12: Every token reaches the output exactly once and in order, with the critical value and data word set by the chain of stage functions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_t | input | 1 | Source critical bit, true rail |
| src_f | input | 1 | Source critical bit, false rail |
| src_data | input | WIDTH | Source single-rail data word |
| sink0_rdy | input | 1 | Consumer 0 is empty and can take a token |
| sink1_rdy | input | 1 | Consumer 1 is empty and can take a token |
| done | output | NSTAGES | Per-stage done (1 = stage at spacer) |
| out_t | output | 1 | Last-stage critical bit, true rail |
| out_f | output | 1 | Last-stage critical bit, false rail |
| out_data | output | WIDTH | Last-stage single-rail data word |

## Verification
The properties assume the source follows the four-phase discipline. It never drives (1,1). It presents a valid token only while done[0] is 1, and it returns to spacer once done[0] falls. They also assume that each consumer drops ready only after taking a valid output and raises it only after seeing spacer. The driver waits on done[0] and drives random garbage onto the data word during every spacer. Each consumer model uses its own random latency, so the two ready signals often disagree and the C-element's hold case is exercised.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  // Dual-rail critical bit: (1,0)=1, (0,1)=0, (0,0)=spacer.
  typedef struct packed {
    logic t;
    logic f;
  } dr_t;

  localparam dr_t DR_SPACER = '{t: 1'b0, f: 1'b0};

  function automatic logic dr_valid(input dr_t x);
    return x.t ^ x.f;
  endfunction
endpackage

// File: rtl/cpc_rail_conv.sv
module cpc_rail_conv
  import cpc_pkg::*;
(
  input  logic arm,
  input  logic bit_in,
  output dr_t  q
);
  // Disarmed gives a valid 0; armed follows the bit. Spacer is unreachable.
  logic hi;
  assign hi  = arm & bit_in;
  assign q.t = hi;
  assign q.f = ~hi;
endmodule

// File: rtl/cpc_sync_and.sv
module cpc_sync_and
  import cpc_pkg::*;
#(
  parameter bit USE_EN = 1'b0
) (
  input  dr_t a,
  input  dr_t b,
  input  dr_t en,
  output dr_t y
);
  logic en_ok;
  assign en_ok = USE_EN ? (en.t | en.f) : 1'b1;

  // One product term per valid input pattern, all of equal depth.
  assign y.t = en_ok & (a.t & b.t);
  assign y.f = en_ok & ((a.t & b.f) | (a.f & (b.t | b.f)));
endmodule

// File: rtl/cpc_stage.sv
module cpc_stage
  import cpc_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit LATCHED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval,
  input  logic             arm,
  input  dr_t              link_in,
  input  logic [WIDTH-1:0] data_in,
  output dr_t              crit_q,
  output logic [WIDTH-1:0] data_q
);
  localparam int NCONV = LATCHED ? 2 : 1;

  dr_t              cv [NCONV];
  dr_t              gate_y;
  dr_t              crit_d;
  logic [WIDTH-1:0] data_d;
  logic             at_spacer;
  logic             fire;
  logic             ld_en;

  for (genvar i = 0; i < NCONV; i++) begin : g_conv
    cpc_rail_conv u_conv (
      .arm    (arm),
      .bit_in (data_in[i]),
      .q      (cv[i])
    );
  end

  if (LATCHED) begin : g_latch
    cpc_sync_and #(.USE_EN(1'b1)) u_gate (
      .a  (cv[0]),
      .b  (cv[1]),
      .en (link_in),
      .y  (gate_y)
    );
  end else begin : g_direct
    cpc_sync_and #(.USE_EN(1'b0)) u_gate (
      .a  (link_in),
      .b  (cv[0]),
      .en (DR_SPACER),
      .y  (gate_y)
    );
  end

  assign at_spacer = ~(crit_q.t | crit_q.f);
  assign fire      = eval & at_spacer & dr_valid(gate_y);
  assign ld_en     = ~eval | fire;

  always_comb begin
    if (!eval) begin
      crit_d = DR_SPACER;
      data_d = '0;
    end else begin
      crit_d = gate_y;
      data_d = {data_in[WIDTH-2:0], data_in[WIDTH-1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_q <= DR_SPACER;
      data_q <= '0;
    end else if (ld_en) begin
      crit_q <= crit_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/cpc_pipeline.sv
module cpc_pipeline
  import cpc_pkg::*;
#(
  parameter int                  NSTAGES    = 4,
  parameter int                  WIDTH      = 8,
  parameter logic [NSTAGES-1:0]  LATCH_MASK = 4'b1010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_t,
  input  logic               src_f,
  input  logic [WIDTH-1:0]   src_data,
  input  logic               sink0_rdy,
  input  logic               sink1_rdy,
  output logic [NSTAGES-1:0] done,
  output logic               out_t,
  output logic               out_f,
  output logic [WIDTH-1:0]   out_data
);
  localparam int LAST = NSTAGES - 1;

  dr_t                            crit [NSTAGES];
  logic [NSTAGES-1:0]             crit_t;
  logic [NSTAGES-1:0]             crit_f;
  logic [NSTAGES-1:0]             done_w;
  logic [NSTAGES-1:0]             stage_eval;
  logic [NSTAGES-1:0]             conv_arm;
  logic [NSTAGES-1:0][WIDTH-1:0]  stage_data;

  // Fork join: C-element over the two consumer ready signals.
  logic join_q;
  logic join_d;
  logic join_en;

  assign join_en = (sink0_rdy == sink1_rdy);
  assign join_d  = join_en ? sink0_rdy : join_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      join_q <= 1'b1;
    end else if (join_en) begin
      join_q <= join_d;
    end
  end

  for (genvar s = 0; s < NSTAGES; s++) begin : g_stage
    dr_t              lnk;
    logic [WIDTH-1:0] din;

    if (s == 0) begin : g_head
      assign lnk.t       = src_t;
      assign lnk.f       = src_f;
      assign din         = src_data;
      assign conv_arm[s] = src_t | src_f;
    end else begin : g_body
      assign lnk         = crit[s-1];
      assign din         = stage_data[s-1];
      assign conv_arm[s] = stage_eval[s-1];
    end

    if (s == LAST) begin : g_tail
      assign stage_eval[s] = join_d;
    end else begin : g_mid
      assign stage_eval[s] = done_w[s+1];
    end

    cpc_stage #(
      .WIDTH   (WIDTH),
      .LATCHED (LATCH_MASK[s])
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .eval    (stage_eval[s]),
      .arm     (conv_arm[s]),
      .link_in (lnk),
      .data_in (din),
      .crit_q  (crit[s]),
      .data_q  (stage_data[s])
    );

    assign crit_t[s] = crit[s].t;
    assign crit_f[s] = crit[s].f;
    assign done_w[s] = ~(crit[s].t | crit[s].f);
  end

  assign done     = done_w;
  assign out_t    = crit_t[LAST];
  assign out_f    = crit_f[LAST];
  assign out_data = stage_data[LAST];
endmodule

// File: rtl/cpc_pipeline_chk.sv
module cpc_pipeline_chk #(
  parameter int NSTAGES = 4,
  parameter int WIDTH   = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           sink0_rdy,
  input logic                           sink1_rdy,
  input logic [NSTAGES-1:0]             done_w,
  input logic [NSTAGES-1:0]             stage_eval,
  input logic [NSTAGES-1:0]             conv_arm,
  input logic [NSTAGES-1:0]             crit_t,
  input logic [NSTAGES-1:0]             crit_f,
  input logic [NSTAGES-1:0][WIDTH-1:0]  stage_data
);
  localparam int LAST = NSTAGES - 1;

  for (genvar s = 0; s < NSTAGES; s++) begin : g_chk
    // R2
    no_double_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(crit_t[s] && crit_f[s]));

    // R4
    eval_only_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_w[s]) |-> $past(stage_eval[s]));

    // R5
    precharge_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stage_eval[s] |=> (done_w[s] && stage_data[s] == '0));

    // R6
    domino_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_w[s] && stage_eval[s]) |=>
        ($stable(crit_t[s]) && $stable(crit_f[s]) && $stable(stage_data[s])));

    // R8
    conv_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_w[s]) |-> $past(conv_arm[s]));

    if (s > 0) begin : g_link
      // R3
      needs_valid_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_w[s]) |-> $past(!done_w[s-1]));
    end
  end

  // R10
  join_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sink0_rdy && !sink1_rdy) |=> done_w[LAST]);

  // R10
  join_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sink0_rdy != sink1_rdy) && !done_w[LAST]) |=> !done_w[LAST]);
endmodule

bind cpc_pipeline cpc_pipeline_chk #(
  .NSTAGES (NSTAGES),
  .WIDTH   (WIDTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sink0_rdy  (sink0_rdy),
  .sink1_rdy  (sink1_rdy),
  .done_w     (done_w),
  .stage_eval (stage_eval),
  .conv_arm   (conv_arm),
  .crit_t     (crit_t),
  .crit_f     (crit_f),
  .stage_data (stage_data)
);

// File: tb/cpc_pipeline_test.sv
module cpc_pipeline_test;
  localparam int             NS   = 4;
  localparam int             W    = 8;
  localparam logic [NS-1:0]  LM   = 4'b1010;
  localparam int             NRND = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          src_t = 1'b0;
  logic          src_f = 1'b0;
  logic [W-1:0]  src_data = '0;
  logic          sink0_rdy = 1'b1;
  logic          sink1_rdy = 1'b1;
  logic [NS-1:0] done;
  logic          out_t;
  logic          out_f;
  logic [W-1:0]  out_data;

  always #10 clk = ~clk;

  cpc_pipeline #(.NSTAGES(NS), .WIDTH(W), .LATCH_MASK(LM)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_t     (src_t),
    .src_f     (src_f),
    .src_data  (src_data),
    .sink0_rdy (sink0_rdy),
    .sink1_rdy (sink1_rdy),
    .done      (done),
    .out_t     (out_t),
    .out_f     (out_f),
    .out_data  (out_data)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  logic [W:0]  exp_q[$];
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R7 / R12 reference chain, written from the stage rules.
  function automatic logic [W:0] model(input logic c, input logic [W-1:0] d);
    logic         cc = c;
    logic [W-1:0] dd = d;
    for (int s = 0; s < NS; s++) begin
      if (LM[s]) cc = dd[0] & dd[1];
      else       cc = cc & dd[0];
      dd = {dd[W-2:0], dd[W-1]};
    end
    return {cc, dd};
  endfunction

  // Driver: four-phase source; garbage data during spacer covers R11.
  task automatic send(input logic c, input logic [W-1:0] d);
    while (done[0] !== 1'b1) @(negedge clk);
    src_t = c;
    src_f = ~c;
    src_data = d;
    exp_q.push_back(model(c, d));
    @(negedge clk);
    while (done[0] !== 1'b0) @(negedge clk);
    src_t = 1'b0;
    src_f = 1'b0;
    src_data = W'($urandom);
  endtask

  // Monitor plus two consumer models.
  initial begin : monitor
    logic         seen = 1'b0;
    logic         pv = 1'b0;
    logic         pdis = 1'b0;
    logic         pt = 1'b0;
    logic [W-1:0] pd = '0;
    int           cnt[2] = '{0, 0};
    logic         rdy[2] = '{1'b1, 1'b1};
    logic         v;
    logic [W:0]   e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        v = out_t | out_f;
        // R2
        if (out_t && out_f) check(1'b0, "R2", {out_t, out_f}, 2'b00);
        // R9
        if (done[NS-1] !== ~(out_t | out_f))
          check(1'b0, "R9", done[NS-1], ~(out_t | out_f));
        if (pv && pdis) begin
          // R10 / R6: disagreeing consumers keep the output valid and steady
          check(v && out_t == pt && out_data == pd, "R10",
                {v, out_t, out_data}, {1'b1, pt, pd});
        end
        if (v && !seen) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R12", {out_t, out_data}, 0);
          end else begin
            e = exp_q.pop_front();
            // R3 R7 R12
            check({out_t, out_data} == e && out_f == ~out_t, "R7/R12",
                  {out_t, out_data}, e);
          end
        end
        if (!v && pv) begin
          // R5
          check(out_data == '0, "R5", out_data, 0);
        end
        seen = v;
        for (int i = 0; i < 2; i++) begin
          if (rdy[i] && v) begin
            if (cnt[i] == 0) begin rdy[i] = 1'b0; cnt[i] = $urandom_range(0, 3 + 2 * i); end
            else cnt[i]--;
          end else if (!rdy[i] && !v) begin
            if (cnt[i] == 0) begin rdy[i] = 1'b1; cnt[i] = $urandom_range(0, 3); end
            else cnt[i]--;
          end
        end
        sink0_rdy = rdy[0];
        sink1_rdy = rdy[1];
        pdis = rdy[0] != rdy[1];
        pv = v;
        pt = out_t;
        pd = out_data;
      end
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1
    check(done == '1, "R1", done, {NS{1'b1}});
    check({out_t, out_f} == 2'b00, "R1", {out_t, out_f}, 0);
    check(out_data == '0, "R1", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: a 1 passes through converters, a 0 keeps the precharge value.
    send(1'b1, 8'hFF);
    send(1'b0, 8'hFF);
    send(1'b1, 8'h00);
    send(1'b1, 8'hAA);
    send(1'b1, 8'h55);
    send(1'b1, 8'h03);
    send(1'b1, 8'h81);
    send(1'b1, 8'hC0);
    send(1'b1, 8'h60);
    for (int k = 0; k < NRND; k++) send(1'($urandom), W'($urandom));
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    // R5: drained pipeline returns to spacer
    check(done == '1, "R5", done, {NS{1'b1}});
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule